// File: doc/BRIEF.md
# In-Place Byte Sorter

This block reorders, in place, the bytes held in an external single-port RAM. A one-cycle `start` pulse launches a run. The 2-bit `order_sel` code chosen at that moment sets two things for the whole run: whether the bytes compare as two's-complement or as unsigned values, and whether the result runs ascending or descending. The block then works through the memory in passes. Each pass walks the adjacent address pairs from the bottom of the memory upward. For each pair it issues two reads. When the pair is out of order, it follows with two writes that exchange the two bytes. A pass that makes no exchange ends the run. In that cycle `done` pulses for one cycle and `busy` falls.

The RAM is external and has a synchronous read: the data for the address presented in one cycle appears on `mem_rdata` in the following cycle. No data stream crosses the block's edge, so every pin is plain control or status, with no valid/ready handshake. The memory depth is a parameter. Its default is 255 entries, and the address width is derived from it.

Top module: `byte_sorter`

## Requirements
- R1: After reset, `busy`, `done` and `mem_wr_en` are all 0.
- R2: A `start` pulse while idle makes `busy` read 1 in the next cycle.
- R3: Code 2'b00 sorts the bytes as two's-complement values, largest at address 0.
- R4: Code 2'b01 sorts the bytes as two's-complement values, smallest at address 0.
- R5: Code 2'b10 sorts the bytes as unsigned values, largest at address 0.
- R6: Code 2'b11 sorts the bytes as unsigned values, smallest at address 0.
- R7: While `busy` is 1, changes on `order_sel` and further `start` pulses have no effect on the result.
- R8: `done` is a single-cycle pulse. `busy` is 0 in that cycle, and the block takes no memory action in it.
- R9: Every address the block presents while busy lies in 0 to DEPTH-1. A write happens only to exchange an out-of-order pair, and the two writes of an exchange go to consecutive addresses.
- R10: On memory that is already in order for the selected code, including memory where every byte is equal, the run performs no writes and stays busy for exactly 3*(DEPTH-1) cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | One-cycle request to begin a sort |
| order_sel | input | 2 | Bit 1: 0 = two's complement, 1 = unsigned. Bit 0: 0 = descending, 1 = ascending |
| mem_addr | output | ADDR_W | RAM address |
| mem_wr_en | output | 1 | RAM write strobe |
| mem_wdata | output | 8 | RAM write data |
| mem_rdata | input | 8 | RAM read data, one cycle after the address |
| busy | output | 1 | High from the cycle after start until the run ends |
| done | output | 1 | One-cycle completion pulse |

## Verification
A wrong internal state reaches the ports as a wrong memory image or a wrong run length, never as a silent internal fault. A corrupted held order code or a bad comparator polarity leaves the final image out of order, so the block is checked against independently sorted references under all four codes. A stuck exchange flag or a wrong end-of-pass index either ends a run early with unsorted memory or makes it run long. For this reason, already-ordered input is timed to the exact cycle count and must produce zero writes. An exchange written to the wrong address shows up as duplicated bytes at the end of that run.

// File: rtl/bsort_pkg.sv
package bsort_pkg;

  typedef enum logic [2:0] {
    S_IDLE,
    S_RD_LO,
    S_RD_HI,
    S_CMP,
    S_WR_LO,
    S_WR_HI,
    S_FIN
  } sort_state_e;

  typedef struct packed {
    logic is_unsigned;
    logic ascending;
  } order_t;

endpackage

// File: rtl/bsort_cmp.sv
module bsort_cmp
  import bsort_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  order_t            ord,
  input  logic [DATA_W-1:0] lo_byte,
  input  logic [DATA_W-1:0] hi_byte,
  output logic              misordered
);

  localparam logic [DATA_W-1:0] SIGN_MASK = {1'b1, {(DATA_W-1){1'b0}}};

  logic [DATA_W-1:0] key_lo;
  logic [DATA_W-1:0] key_hi;

  // Flipping the sign bit maps two's-complement order onto unsigned order.
  always_comb begin
    key_lo = ord.is_unsigned ? lo_byte : (lo_byte ^ SIGN_MASK);
    key_hi = ord.is_unsigned ? hi_byte : (hi_byte ^ SIGN_MASK);
    if (ord.ascending) misordered = (key_lo > key_hi);
    else               misordered = (key_lo < key_hi);
  end

endmodule

// File: rtl/bsort_datapath.sv
module bsort_datapath
  import bsort_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_mode,
  input  logic [1:0]        mode_in,
  input  logic              capture_lo,
  input  logic              capture_hi,
  input  logic              wr_sel_hi,
  input  logic [DATA_W-1:0] rdata,
  output order_t            ord,
  output logic [DATA_W-1:0] lo_q,
  output logic [DATA_W-1:0] wdata
);

  logic [DATA_W-1:0] hi_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ord  <= '0;
      lo_q <= '0;
      hi_q <= '0;
    end else begin
      if (load_mode)  ord  <= order_t'(mode_in);
      if (capture_lo) lo_q <= rdata;
      if (capture_hi) hi_q <= rdata;
    end
  end

  // The first write of an exchange stores the upper byte at the lower address.
  assign wdata = wr_sel_hi ? hi_q : lo_q;

endmodule

// File: rtl/bsort_ctrl.sv
module bsort_ctrl
  import bsort_pkg::*;
#(
  parameter int DEPTH  = 255,
  parameter int ADDR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              misordered,
  output logic              load_mode,
  output logic              capture_lo,
  output logic              capture_hi,
  output logic              wr_sel_hi,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_wr_en,
  output logic              busy,
  output logic              done
);

  localparam logic [ADDR_W-1:0] LAST_PAIR = ADDR_W'(DEPTH - 2);

  sort_state_e       state, state_nx;
  logic [ADDR_W-1:0] idx, idx_nx;
  logic              swapped, swapped_nx;
  logic              last_pair;

  assign last_pair = (idx == LAST_PAIR);

  always_comb begin
    state_nx   = state;
    idx_nx     = idx;
    swapped_nx = swapped;
    load_mode  = 1'b0;
    capture_lo = 1'b0;
    capture_hi = 1'b0;
    wr_sel_hi  = 1'b0;
    mem_addr   = idx;
    mem_wr_en  = 1'b0;
    unique case (state)
      S_IDLE: begin
        mem_addr = '0;
        if (start) begin
          load_mode  = 1'b1;
          idx_nx     = '0;
          swapped_nx = 1'b0;
          state_nx   = S_RD_LO;
        end
      end
      S_RD_LO: state_nx = S_RD_HI;
      S_RD_HI: begin
        mem_addr   = idx + 1'b1;
        capture_lo = 1'b1;
        state_nx   = S_CMP;
      end
      S_CMP: begin
        capture_hi = 1'b1;
        if (misordered) state_nx = S_WR_LO;
        else if (!last_pair) begin
          idx_nx   = idx + 1'b1;
          state_nx = S_RD_LO;
        end else if (swapped) begin
          idx_nx     = '0;
          swapped_nx = 1'b0;
          state_nx   = S_RD_LO;
        end else state_nx = S_FIN;
      end
      S_WR_LO: begin
        mem_wr_en = 1'b1;
        wr_sel_hi = 1'b1;
        state_nx  = S_WR_HI;
      end
      S_WR_HI: begin
        mem_addr  = idx + 1'b1;
        mem_wr_en = 1'b1;
        state_nx  = S_RD_LO;
        if (!last_pair) begin
          idx_nx     = idx + 1'b1;
          swapped_nx = 1'b1;
        end else begin
          idx_nx     = '0;
          swapped_nx = 1'b0;
        end
      end
      S_FIN: begin
        mem_addr = '0;
        state_nx = S_IDLE;
      end
      default: state_nx = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= S_IDLE;
      idx     <= '0;
      swapped <= 1'b0;
    end else begin
      state   <= state_nx;
      idx     <= idx_nx;
      swapped <= swapped_nx;
    end
  end

  assign busy = (state != S_IDLE) && (state != S_FIN);
  assign done = (state == S_FIN);

  assert_addr_range_R9: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (int'(mem_addr) < DEPTH));

  assert_swap_pair_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_WR_LO) |=> (mem_wr_en && mem_addr == $past(mem_addr) + 1'b1));

  assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_done_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && !mem_wr_en));

  assert_start_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_IDLE && start) |=> busy);

endmodule

// File: rtl/byte_sorter.sv
module byte_sorter
  import bsort_pkg::*;
#(
  parameter int DEPTH  = 255,
  parameter int ADDR_W = $clog2(DEPTH),
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [1:0]        order_sel,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_wr_en,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              busy,
  output logic              done
);

  order_t            ord;
  logic [DATA_W-1:0] lo_q;
  logic              misordered;
  logic              load_mode;
  logic              capture_lo;
  logic              capture_hi;
  logic              wr_sel_hi;

  bsort_ctrl #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .misordered (misordered),
    .load_mode  (load_mode),
    .capture_lo (capture_lo),
    .capture_hi (capture_hi),
    .wr_sel_hi  (wr_sel_hi),
    .mem_addr   (mem_addr),
    .mem_wr_en  (mem_wr_en),
    .busy       (busy),
    .done       (done)
  );

  bsort_datapath #(.DATA_W(DATA_W)) u_dp (
    .clk        (clk),
    .rst_n      (rst_n),
    .load_mode  (load_mode),
    .mode_in    (order_sel),
    .capture_lo (capture_lo),
    .capture_hi (capture_hi),
    .wr_sel_hi  (wr_sel_hi),
    .rdata      (mem_rdata),
    .ord        (ord),
    .lo_q       (lo_q),
    .wdata      (mem_wdata)
  );

  bsort_cmp #(.DATA_W(DATA_W)) u_cmp (
    .ord        (ord),
    .lo_byte    (lo_q),
    .hi_byte    (mem_rdata),
    .misordered (misordered)
  );

  assert_mode_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(ord));

  assert_reset_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(rst_n)) |-> (!busy && !done));

endmodule

// File: tb/sim_byte_sorter.sv
module sim_byte_sorter;

  localparam int DEPTH  = 16;
  localparam int ADDR_W = $clog2(DEPTH);
  localparam int LIMIT  = 20000;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              start = 1'b0;
  logic [1:0]        order_sel = 2'b00;
  logic [ADDR_W-1:0] mem_addr;
  logic              mem_wr_en;
  logic [7:0]        mem_wdata;
  logic [7:0]        mem_rdata;
  logic              busy;
  logic              done;

  int n_tests = 0;
  int n_fail  = 0;

  logic [7:0] mem  [DEPTH];
  logic [7:0] expv [DEPTH];

  always #2 clk = ~clk;

  always @(posedge clk) begin
    if (mem_wr_en) mem[mem_addr] <= mem_wdata;
    mem_rdata <= mem[mem_addr];
  end

  byte_sorter #(.DEPTH(DEPTH)) u0 (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .order_sel (order_sel),
    .mem_addr  (mem_addr),
    .mem_wr_en (mem_wr_en),
    .mem_wdata (mem_wdata),
    .mem_rdata (mem_rdata),
    .busy      (busy),
    .done      (done)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Integer sort key: signed codes use the two's-complement value.
  function automatic int keyv(input logic [7:0] v, input logic [1:0] m);
    return m[1] ? int'(v) : int'($signed(v));
  endfunction

  function automatic bit goes_first(input logic [7:0] a, input logic [7:0] b,
                                    input logic [1:0] m);
    return m[0] ? (keyv(a, m) < keyv(b, m)) : (keyv(a, m) > keyv(b, m));
  endfunction

  task automatic build_expected(input logic [1:0] m);
    for (int i = 0; i < DEPTH; i++) expv[i] = mem[i];
    for (int i = 1; i < DEPTH; i++) begin
      for (int j = i; j > 0; j--) begin
        if (goes_first(expv[j], expv[j-1], m)) begin
          logic [7:0] t;
          t = expv[j]; expv[j] = expv[j-1]; expv[j-1] = t;
        end
      end
    end
  endtask

  task automatic compare_mem(input string req);
    for (int i = 0; i < DEPTH; i++) chk(mem[i] === expv[i], req, mem[i], expv[i]);
  endtask

  task automatic fill(input int seed);
    for (int i = 0; i < DEPTH; i++) mem[i] = 8'((i * 37 + seed * 91 + 8'h5A) & 8'hFF);
    mem[0] = 8'h80;
    mem[1] = 8'h7F;
    mem[2] = 8'h00;
    mem[3] = 8'hFF;
  endtask

  // Runs one sort; optionally disturbs order_sel/start mid-run.
  task automatic run_sort(input logic [1:0] m, input bit disturb,
                          output int cycles, output int writes);
    int n;
    cycles = 0;
    writes = 0;
    n = 0;
    @(negedge clk);
    order_sel = m;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(busy === 1'b1, "R2 busy after start", busy, 1);
    while (!done && n < LIMIT) begin
      if (busy) cycles++;
      if (mem_wr_en) writes++;
      if (busy && int'(mem_addr) >= DEPTH) chk(1'b0, "R9 address range", mem_addr, DEPTH - 1);
      if (disturb && n == 5) begin order_sel = ~m; start = 1'b1; end
      if (disturb && n == 6) start = 1'b0;
      @(negedge clk);
      n++;
    end
    chk(n < LIMIT, "R8 done reached (watchdog)", n, LIMIT);
    chk(busy === 1'b0 && mem_wr_en === 1'b0, "R8 quiet during done", busy, 0);
    @(negedge clk);
    chk(done === 1'b0, "R8 done one cycle", done, 0);
    order_sel = m;
  endtask

  task automatic t_reset;
    chk(busy === 1'b0, "R1 busy at reset", busy, 0);
    chk(done === 1'b0, "R1 done at reset", done, 0);
    chk(mem_wr_en === 1'b0, "R1 wr_en at reset", mem_wr_en, 0);
  endtask

  task automatic t_mode(input logic [1:0] m, input int seed, input string req);
    int c, w;
    fill(seed);
    build_expected(m);
    run_sort(m, 1'b0, c, w);
    compare_mem(req);
  endtask

  task automatic t_presorted(input logic [1:0] m);
    int c, w;
    fill(7);
    build_expected(m);
    for (int i = 0; i < DEPTH; i++) mem[i] = expv[i];
    run_sort(m, 1'b0, c, w);
    chk(w == 0, "R10 no writes on ordered data", w, 0);
    chk(c == 3 * (DEPTH - 1), "R10 busy length", c, 3 * (DEPTH - 1));
    compare_mem("R10 ordered data unchanged");
  endtask

  task automatic t_all_equal;
    int c, w;
    for (int i = 0; i < DEPTH; i++) mem[i] = 8'hA5;
    run_sort(2'b01, 1'b0, c, w);
    chk(w == 0, "R10 equal bytes never exchanged", w, 0);
    chk(c == 3 * (DEPTH - 1), "R10 equal bytes busy length", c, 3 * (DEPTH - 1));
  endtask

  task automatic t_disturb;
    int c, w;
    fill(3);
    build_expected(2'b11);
    run_sort(2'b11, 1'b1, c, w);
    compare_mem("R7 mode change ignored while busy");
  endtask

  initial begin
    #1;
    t_reset();
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_mode(2'b00, 1, "R3 signed descending");
    t_mode(2'b01, 2, "R4 signed ascending");
    t_mode(2'b10, 4, "R5 unsigned descending");
    t_mode(2'b11, 5, "R6 unsigned ascending");
    t_presorted(2'b00);
    t_presorted(2'b11);
    t_all_equal();
    t_disturb();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule